// File: doc/BRIEF.md
# Matrix Keypad Scanner Encoder

This block scans a keypad of crossing rows and columns, by default four of each. It drives exactly one row high at a time and reads the column lines, which rest low through external pull-downs. A closed key at the crossing of the driven row and a column pulls that column high. A free-running binary divider sets how long each row stays selected: 2^SCAN_DIV_LOG2 clocks. The column lines pass through a two-flop synchronizer, and the controller looks at them once per row slot, on the cycle just before the row moves on.

When the controller sees a closed key, it stops the scan on that row. It loads the key code, which is the row index times the column count plus the column index. One cycle later it raises the key-down flag. The scan stays frozen until every column reads low again. At that point the flag drops and the rotation continues. The code keeps the last key after release. Neither output moves while the rows are being cycled. The block assumes that at most one key is closed at a time and that every key is released between presses.

Top module: `kp_scanner`

## Requirements
- R1: While reset is high and on the first cycle after it, key_code_o is 0, key_down_o is 0 and rows_o is 4'b0001 (row 0 selected).
- R2: rows_o always has exactly one bit set. With no key closed, the selected row moves 0→1→2→3→0, and each row stays selected for 2^SCAN_DIV_LOG2 clocks.
- R3: A closed key in row r and column c yields key_code_o = 4*r + c. Row 0 is bit 0 of rows_o and column 0 is bit 0 of cols_i, so the top-left key is 0 and the bottom-right key is 15.
- R4: After the key is released, key_code_o keeps the last code until a different key is detected.
- R5: key_down_o is 1 while the key is held and returns to 0 after release. On a new press, key_down_o rises exactly one cycle after key_code_o takes the new value, and key_code_o never changes in the cycle in which key_down_o rises.
- R6: While no key is closed, key_code_o and key_down_o do not change at all as the rows are cycled.
- R7: While key_down_o is 1, rows_o stays on the row of the held key.
- R8: Pressing the same key again leaves key_code_o unchanged and gives exactly one more rising edge of key_down_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cols_i | input | COLS | Column sense lines, high when a key in the driven row is closed |
| rows_o | output | ROWS | Row drive lines; the selected row is high |
| key_code_o | output | CODE_W | Code of the last detected key |
| key_down_o | output | 1 | High while the detected key is held |

## Verification
The bench builds the block with SCAN_DIV_LOG2 = 3, so each row is selected for eight clocks and a full scan takes 32 clocks. At this setting the exact slot length and the row order can be measured directly. All sixteen key positions, releases, repeated presses and long idle windows also fit in a short run. ROWS and COLS keep their default value of four, so all sixteen codes and the wrap from row 3 back to row 0 are exercised.

// File: rtl/kp_pkg.sv
package kp_pkg;

    typedef enum logic [1:0] {
        KP_SCAN = 2'd0,
        KP_ARM  = 2'd1,
        KP_HOLD = 2'd2
    } kp_state_e;

    typedef struct packed {
        logic       any;
        logic [7:0] idx;
    } kp_hit_t;

    function automatic int kp_code(input int row_idx, input int col_idx, input int cols);
        return row_idx * cols + col_idx;
    endfunction

    function automatic int kp_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/kp_div.sv
module kp_div #(
    parameter int N = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    logic [N-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = &cnt_q;
endmodule

// File: rtl/kp_sync.sv
module kp_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/kp_ctrl.sv
module kp_ctrl
    import kp_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int ROW_W  = kp_width(ROWS),
    localparam int CODE_W = kp_width(ROWS * COLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [COLS-1:0]   cols_i,
    output logic [ROW_W-1:0]  row_idx_o,
    output logic [CODE_W-1:0] code_o,
    output logic              flag_o
);
    kp_state_e         state_q;
    logic [ROW_W-1:0]  row_q;
    logic [CODE_W-1:0] code_q;
    logic              flag_q;
    kp_hit_t           hit;
    logic [ROW_W-1:0]  row_next;

    always_comb begin
        hit = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (cols_i[c]) begin
                hit.any = 1'b1;
                hit.idx = 8'(c);
            end
        end
    end

    assign row_next = (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KP_SCAN;
            row_q   <= '0;
            code_q  <= '0;
            flag_q  <= 1'b0;
        end else begin
            case (state_q)
                KP_SCAN: begin
                    if (tick_i) begin
                        if (hit.any) begin
                            code_q  <= CODE_W'(kp_code(int'(row_q), int'(hit.idx), COLS));
                            state_q <= KP_ARM;
                        end else begin
                            row_q <= row_next;
                        end
                    end
                end
                KP_ARM: begin
                    flag_q  <= 1'b1;
                    state_q <= KP_HOLD;
                end
                KP_HOLD: begin
                    if (tick_i && !hit.any) begin
                        flag_q  <= 1'b0;
                        row_q   <= row_next;
                        state_q <= KP_SCAN;
                    end
                end
                default: state_q <= KP_SCAN;
            endcase
        end
    end

    assign row_idx_o = row_q;
    assign code_o    = code_q;
    assign flag_o    = flag_q;
endmodule

// File: rtl/kp_scanner.sv
module kp_scanner
    import kp_pkg::*;
#(
    parameter int ROWS          = 4,
    parameter int COLS          = 4,
    parameter int SCAN_DIV_LOG2 = 12,
    localparam int ROW_W  = kp_width(ROWS),
    localparam int CODE_W = kp_width(ROWS * COLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COLS-1:0]   cols_i,
    output logic [ROWS-1:0]   rows_o,
    output logic [CODE_W-1:0] key_code_o,
    output logic              key_down_o
);
    logic             tick;
    logic [COLS-1:0]  cols_s;
    logic [ROW_W-1:0] row_idx;

    kp_div #(.N(SCAN_DIV_LOG2)) div_i (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    kp_sync #(.W(COLS)) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (cols_i),
        .q_o (cols_s)
    );

    kp_ctrl #(.ROWS(ROWS), .COLS(COLS)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .cols_i    (cols_s),
        .row_idx_o (row_idx),
        .code_o    (key_code_o),
        .flag_o    (key_down_o)
    );

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign rows_o[r] = (row_idx == ROW_W'(r));
        end
    endgenerate
endmodule

// File: rtl/kp_scanner_chk.sv
module kp_scanner_chk #(
    parameter int ROWS   = 4,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ROWS-1:0]   rows,
    input logic [CODE_W-1:0] code,
    input logic              flag
);
    assert_one_row_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(rows) == 1);

    assert_flag_rise_code_stable_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $stable(code));

    assert_code_then_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (code != $past(code)) |=> flag);

    assert_code_moves_only_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (code != $past(code)) |-> !$past(flag));

    assert_row_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (flag && $past(flag)) |-> $stable(rows));
endmodule

bind kp_scanner kp_scanner_chk #(.ROWS(ROWS), .CODE_W(CODE_W)) chk_i (
    .clk  (clk),
    .rst  (rst),
    .rows (rows_o),
    .code (key_code_o),
    .flag (key_down_o)
);

// File: tb/kp_scanner_tb_top.sv
`timescale 1ns/100ps
module kp_scanner_tb_top;
    localparam int DIVL = 3;
    localparam int SLOT = 1 << DIVL;
    localparam int WAIT = 12 * SLOT;

    localparam logic [11:0] VEC [0:15] = '{
        12'h000, 12'h33F, 12'h126, 12'h219, 12'h033, 12'h30C, 12'h104, 12'h23B,
        12'h011, 12'h32E, 12'h137, 12'h208, 12'h022, 12'h31D, 12'h115, 12'h22A
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cols;
    logic [3:0] rows;
    logic [3:0] code;
    logic       flag;

    logic       pressed = 1'b0;
    logic [1:0] prow = '0;
    logic [1:0] pcol = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int code_chg = 0, flag_rise = 0, flag_fall = 0, row_chg = 0, order_bad = 0;
    logic [3:0] code_p = '0, rows_p = 4'b0001;
    logic       flag_p = 1'b0;

    always #2.5 clk = ~clk;

    always_comb cols = (pressed && rows[prow]) ? (4'b0001 << pcol) : 4'b0000;

    kp_scanner #(.SCAN_DIV_LOG2(DIVL)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .cols_i     (cols),
        .rows_o     (rows),
        .key_code_o (code),
        .key_down_o (flag)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (code != code_p) code_chg++;
            if (flag && !flag_p) begin
                flag_rise++;
                if (code != code_p) order_bad++;
            end
            if (!flag && flag_p) flag_fall++;
            if (rows != rows_p) row_chg++;
        end
        code_p = code;
        flag_p = flag;
        rows_p = rows;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle(3);
        chk("R1 code in reset", int'(code), 0);
        chk("R1 flag in reset", int'(flag), 0);
        chk("R1 rows in reset", int'(rows), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rows after reset", int'(rows), 1);
        chk("R1 code after reset", int'(code), 0);
    endtask

    task automatic press(input logic [1:0] r, input logic [1:0] c, input logic [3:0] exp);
        int cc0, fr0, rc0;
        prow = r; pcol = c; pressed = 1'b1;
        idle(WAIT);
        chk("R3 code for key", int'(code), int'(exp));
        chk("R5 flag held", int'(flag), 1);
        cc0 = code_chg; fr0 = flag_rise; rc0 = row_chg;
        idle(WAIT);
        chk("R7 row held", int'(rows), int'(4'b0001 << r));
        chk("R7 no row motion in hold", row_chg - rc0, 0);
        chk("R6 outputs stable in hold", (code_chg - cc0) + (flag_rise - fr0), 0);
        pressed = 1'b0;
        idle(WAIT);
        chk("R5 flag cleared", int'(flag), 0);
        chk("R4 code kept", int'(code), int'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int rc0, fr0, cc0, gap;
        logic [3:0] prev;
        do_reset();

        // R2 slot length and rotation order, including wrap 3 -> 0
        prev = rows;
        while (rows == prev) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            prev = rows;
            gap = 0;
            while (rows == prev) begin
                @(negedge clk);
                gap++;
            end
            chk("R2 slot length", gap, SLOT);
            chk("R2 next row", int'(rows), int'({prev[2:0], prev[3]}));
            chk("R2 one row", $countones(rows), 1);
        end

        // R6 idle scanning leaves outputs frozen
        cc0 = code_chg; fr0 = flag_rise;
        idle(20 * SLOT);
        chk("R6 idle code changes", code_chg - cc0, 0);
        chk("R6 idle flag changes", flag_rise - fr0, 0);

        // R3/R4/R5/R7 every key from the table
        for (int i = 0; i < 16; i++) begin
            fr0 = flag_rise;
            press(VEC[i][9:8], VEC[i][5:4], VEC[i][3:0]);
            chk("R5 one rise per press", flag_rise - fr0, 1);
        end
        chk("R5 flag after code ordering", order_bad, 0);

        // R8 same key twice
        press(2'd1, 2'd1, 4'd5);
        cc0 = code_chg; fr0 = flag_rise;
        press(2'd1, 2'd1, 4'd5);
        chk("R8 code unchanged", code_chg - cc0, 0);
        chk("R8 one more rise", flag_rise - fr0, 1);

        // R1 reset after activity
        press(2'd3, 2'd2, 4'd14);
        do_reset();
        chk("R1 flag after second reset", int'(flag), 0);
        press(2'd0, 2'd0, 4'd0);
        chk("R5 ordering final", order_bad, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule